// File: doc/BRIEF.md
# Dual-Profile Raster Timing Generator

This block produces the horizontal and vertical timing strobes for a bitmap display. It counts on a clock enable that pulses once every two pixel clocks, so each horizontal position is a pair of pixels. Along each scan line it drives horizontal blank, horizontal sync and a one-position half-line marker at the exact centre of the line. For interlaced scanning it counts scan lines per field and drives vertical blank and vertical sync. A one-clock wake strobe marks the first visible line of every field, and an even/odd field flag flips at each field boundary.

Two fixed monitor profiles are built in. Profile A is a small landscape monitor and profile B is a larger full-page monitor. Software picks one with a select pin. The block takes the selection at reset and then only at a field boundary, so a field is never drawn with mixed timing. The current position and line counts are outputs, so that a pixel fetch engine can follow the raster.

Top module: `raster_timing_gen`

## Requirements
- R1: When synchronous reset is high, h_pos and v_line go to 0, hblank and vblank go to 1, and hsync, vsync, halfline, field_wake and odd_field go to 0.
- R2: The counters and all timing strobes change only on a clock edge where hc_en is 1. Each enabled edge moves h_pos up by one. After the last position (383 for profile A, 719 for profile B) h_pos wraps to 0, which gives a line period of 384 or 720 enable periods.
- R3: hblank is 1 exactly when h_pos is at or above the visible width in half-clocks (304 for A, 512 for B). It is therefore high for 80 positions per line on A and 208 on B.
- R4: hsync rises at position 323 (A) or 525 (B) and stays high for 35 (A) or 180 (B) positions. It is high only while hblank is high.
- R5: halfline is high for exactly one position per line, at h_pos 192 (A) or 360 (B), which is half the line length.
- R6: v_line advances by one on each line wrap and wraps to 0 after the last line of the field. A field is VIS_LINES+33 lines on A (437 by default) and VIS_LINES+44 lines on B (448 by default).
- R7: vblank is 1 from line VIS_LINES (404 by default) through the last line of the field, and 0 on lines below VIS_LINES.
- R8: vsync rises 2 lines (A) or 9 lines (B) after vblank rises and lasts 19 lines. It is high only while vblank is high.
- R9: field_wake is a single-clock pulse. It appears in the cycle where the counters first show line 0, position 0 of a new field. odd_field toggles at that same edge.
- R10: prof_sel (0 selects A, 1 selects B) is taken during reset and at the field wrap. A change at any other time has no effect until the next field begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hc_en | input | 1 | Half-pixel-clock enable, one clock wide |
| prof_sel | input | 1 | Monitor profile request: 0 = A, 1 = B |
| h_pos | output | HW | Position within the line, in half-clocks |
| v_line | output | VW | Line within the field |
| hblank | output | 1 | Horizontal blanking |
| hsync | output | 1 | Horizontal sync |
| halfline | output | 1 | Mid-line marker for interlace |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| field_wake | output | 1 | One-clock start-of-field strobe |
| odd_field | output | 1 | Field parity flag |

## Verification
The assertions assume that hc_en is an ordinary single-clock enable and that prof_sel does not change during the last reset cycle. The profile-hold and parity properties are only valid under that second assumption. The stimulus holds prof_sel steady through reset and changes it once, in the middle of a visible line. It first runs hc_en toggling every clock, then high continuously, and it holds the enable low for a short stretch right after reset. To keep run time bounded, the bench shortens the visible line count of a field. Every horizontal value and every vertical porch and sync value stays at its real figure.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Horizontal edges, in half-clock positions.
  typedef struct packed {
    logic [15:0] htot;
    logic [15:0] hvis;
    logic [15:0] hss;
    logic [15:0] hse;
  } rtg_hprof_t;

  // Vertical edges, in scan lines.
  typedef struct packed {
    logic [15:0] vvis;
    logic [15:0] vss;
    logic [15:0] vse;
    logic [15:0] vtot;
  } rtg_vprof_t;

  typedef struct packed {
    rtg_hprof_t h;
    rtg_vprof_t v;
  } rtg_prof_t;

  // Turn pixel-domain and line-domain figures into counter edges.
  function automatic rtg_prof_t rtg_make(input int tot_px, input int vis_px,
                                         input int fp_px, input int sync_px,
                                         input int vis_lines, input int vb_to_vs,
                                         input int vs_lines, input int vs_to_end);
    rtg_prof_t p;
    p.h.htot = 16'(tot_px / 2);
    p.h.hvis = 16'(vis_px / 2);
    p.h.hss  = 16'((vis_px + fp_px) / 2);
    p.h.hse  = 16'((vis_px + fp_px + sync_px) / 2);
    p.v.vvis = 16'(vis_lines);
    p.v.vss  = 16'(vis_lines + vb_to_vs);
    p.v.vse  = 16'(vis_lines + vb_to_vs + vs_lines);
    p.v.vtot = 16'(vis_lines + vb_to_vs + vs_lines + vs_to_end);
    return p;
  endfunction

endpackage

// File: rtl/rtg_hcnt.sv
module rtg_hcnt
  import rtg_pkg::*;
#(
  parameter int HW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  rtg_hprof_t    prof,
  output logic [HW-1:0] pos,
  output logic          line_end,
  output logic          hblank,
  output logic          hsync,
  output logic          halfline
);

  logic [15:0]   cur_w;
  logic [15:0]   nxt_w;
  logic          at_end;
  logic [HW-1:0] pos_n;

  assign cur_w    = 16'(pos);
  assign at_end   = (cur_w == prof.htot - 16'd1);
  assign pos_n    = at_end ? '0 : pos + 1'b1;
  assign nxt_w    = 16'(pos_n);
  assign line_end = adv & at_end;

  // Strobes are decoded from the next count so they line up with pos.
  always_ff @(posedge clk) begin
    if (rst) begin
      pos      <= '0;
      hblank   <= 1'b1;
      hsync    <= 1'b0;
      halfline <= 1'b0;
    end else if (adv) begin
      pos      <= pos_n;
      hblank   <= (nxt_w >= prof.hvis);
      hsync    <= (nxt_w >= prof.hss) && (nxt_w < prof.hse);
      halfline <= (nxt_w == (prof.htot >> 1));
    end
  end

  assert_pos_range_R2 : assert property (@(posedge clk) disable iff (rst)
    cur_w < prof.htot);

  assert_hold_R2 : assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(pos) && $stable(hblank) && $stable(hsync));

  assert_hsync_in_blank_R4 : assert property (@(posedge clk) disable iff (rst)
    hsync |-> hblank);

endmodule

// File: rtl/rtg_vcnt.sv
module rtg_vcnt
  import rtg_pkg::*;
#(
  parameter int VW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  rtg_vprof_t    prof,
  output logic [VW-1:0] line,
  output logic          field_end,
  output logic          vblank,
  output logic          vsync
);

  logic [15:0]   cur_w;
  logic [15:0]   nxt_w;
  logic          last;
  logic [VW-1:0] line_n;

  assign cur_w     = 16'(line);
  assign last      = (cur_w == prof.vtot - 16'd1);
  assign line_n    = last ? '0 : line + 1'b1;
  assign nxt_w     = 16'(line_n);
  assign field_end = adv & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      line   <= '0;
      vblank <= 1'b1;
      vsync  <= 1'b0;
    end else if (adv) begin
      line   <= line_n;
      vblank <= (nxt_w >= prof.vvis);
      vsync  <= (nxt_w >= prof.vss) && (nxt_w < prof.vse);
    end
  end

  assert_line_range_R6 : assert property (@(posedge clk) disable iff (rst)
    cur_w < prof.vtot);

  assert_vsync_in_vblank_R8 : assert property (@(posedge clk) disable iff (rst)
    vsync |-> vblank);

endmodule

// File: rtl/rtg_field.sv
module rtg_field
  import rtg_pkg::*;
#(
  parameter rtg_prof_t PROF_A = '0,
  parameter rtg_prof_t PROF_B = '0
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      field_end,
  input  logic      prof_sel,
  output rtg_prof_t prof,
  output logic      field_wake,
  output logic      odd_field
);

  logic prof_q;
  logic rst_d;

  // Profile is loaded in reset and only on the field wrap afterwards.
  always_ff @(posedge clk) begin
    if (rst) begin
      prof_q     <= prof_sel;
      field_wake <= 1'b0;
      odd_field  <= 1'b0;
    end else begin
      field_wake <= field_end;
      if (field_end) begin
        prof_q    <= prof_sel;
        odd_field <= ~odd_field;
      end
    end
  end

  always_ff @(posedge clk) rst_d <= rst;

  assign prof = prof_q ? PROF_B : PROF_A;

  assert_wake_single_R9 : assert property (@(posedge clk) disable iff (rst)
    field_wake |=> !field_wake);

  assert_prof_hold_R10 : assert property (@(posedge clk) disable iff (rst || rst_d)
    !field_wake |-> $stable(prof_q));

  assert_odd_hold_R9 : assert property (@(posedge clk) disable iff (rst || rst_d)
    !field_wake |-> $stable(odd_field));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int HW          = 10,
  parameter int VW          = 9,
  parameter int VIS_LINES   = 404,
  parameter int VS_LINES    = 19,
  parameter int A_TOTAL_PX  = 768,
  parameter int A_VIS_PX    = 608,
  parameter int A_FP_PX     = 38,
  parameter int A_SYNC_PX   = 70,
  parameter int A_VB_TO_VS  = 2,
  parameter int A_VS_TO_END = 12,
  parameter int B_TOTAL_PX  = 1440,
  parameter int B_VIS_PX    = 1024,
  parameter int B_FP_PX     = 26,
  parameter int B_SYNC_PX   = 360,
  parameter int B_VB_TO_VS  = 9,
  parameter int B_VS_TO_END = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hc_en,
  input  logic          prof_sel,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_line,
  output logic          hblank,
  output logic          hsync,
  output logic          halfline,
  output logic          vblank,
  output logic          vsync,
  output logic          field_wake,
  output logic          odd_field
);

  localparam rtg_prof_t PROF_A = rtg_make(A_TOTAL_PX, A_VIS_PX, A_FP_PX, A_SYNC_PX,
                                          VIS_LINES, A_VB_TO_VS, VS_LINES, A_VS_TO_END);
  localparam rtg_prof_t PROF_B = rtg_make(B_TOTAL_PX, B_VIS_PX, B_FP_PX, B_SYNC_PX,
                                          VIS_LINES, B_VB_TO_VS, VS_LINES, B_VS_TO_END);

  rtg_prof_t prof;
  logic      line_end;
  logic      field_end;

  rtg_field #(.PROF_A(PROF_A), .PROF_B(PROF_B)) u_field (
    .clk        (clk),
    .rst        (rst),
    .field_end  (field_end),
    .prof_sel   (prof_sel),
    .prof       (prof),
    .field_wake (field_wake),
    .odd_field  (odd_field)
  );

  rtg_hcnt #(.HW(HW)) u_h (
    .clk      (clk),
    .rst      (rst),
    .adv      (hc_en),
    .prof     (prof.h),
    .pos      (h_pos),
    .line_end (line_end),
    .hblank   (hblank),
    .hsync    (hsync),
    .halfline (halfline)
  );

  rtg_vcnt #(.VW(VW)) u_v (
    .clk       (clk),
    .rst       (rst),
    .adv       (line_end),
    .prof      (prof.v),
    .line      (v_line),
    .field_end (field_end),
    .vblank    (vblank),
    .vsync     (vsync)
  );

  assert_wake_origin_R9 : assert property (@(posedge clk) disable iff (rst)
    field_wake |-> (h_pos == '0) && (v_line == '0) && !hblank && !vblank);

endmodule

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  localparam int HW  = 10;
  localparam int VW  = 9;
  localparam int VIS = 8;
  localparam int NK  = 10;
  localparam int K_HSW = 0, K_HSO = 1, K_HBW = 2, K_HPER = 3, K_HALF = 4;
  localparam int K_VBL = 5, K_VBW = 6, K_VSO = 7, K_VSW = 8, K_FLD = 9;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, psel = 1'b0;
  logic [HW-1:0] h_pos;
  logic [VW-1:0] v_line;
  logic hblank, hsync, halfline, vblank, vsync, field_wake, odd_field;

  always #4 clk = ~clk;

  raster_timing_gen #(.HW(HW), .VW(VW), .VIS_LINES(VIS)) u0 (
    .clk(clk), .rst(rst), .hc_en(en), .prof_sel(psel),
    .h_pos(h_pos), .v_line(v_line), .hblank(hblank), .hsync(hsync),
    .halfline(halfline), .vblank(vblank), .vsync(vsync),
    .field_wake(field_wake), .odd_field(odd_field));

  typedef struct { int v; string r; } exp_t;
  exp_t q [NK][$];
  string kreq [NK] = '{"R4", "R4", "R3", "R2", "R5", "R7", "R7", "R8", "R8", "R6"};

  int n_tests = 0, n_fail = 0;
  int en_mode = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(string r, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", r, act, exp);
    end
  endtask

  // Monitor side: pop the next expected item of a kind and compare.
  task automatic observe(int k, int v);
    if (q[k].size() > 0) begin
      exp_t e;
      e = q[k].pop_front();
      chk(e.r, v, e.v);
    end
  endtask

  // Driver side: push expected items.
  task automatic push(int k, int v, string r, int n);
    for (int i = 0; i < n; i++) q[k].push_back('{v, r});
  endtask

  task automatic expect_profile(bit p);
    push(K_HSW,  p ? 180 : 35,  "R4", 3);
    push(K_HSO,  p ? 525 : 323, "R4", 3);
    push(K_HBW,  p ? 208 : 80,  "R3", 3);
    push(K_HPER, p ? 720 : 384, "R2", 3);
    push(K_HALF, p ? 360 : 192, "R5", 3);
    push(K_VBL,  VIS,           "R7", 1);
    push(K_VBW,  p ? 44 : 33,   "R7", 1);
    push(K_VSO,  p ? 9 : 2,     "R8", 1);
    push(K_VSW,  19,            "R8", 1);
    push(K_FLD,  p ? VIS + 44 : VIS + 33, "R6", 1);
  endtask

  // Monitor state
  int tick = 0, lt = 0;
  bit p_hs = 0, p_hb = 1, p_hl = 0, p_vs = 0, p_vb = 1, hb_on = 0, vb_on = 0;
  int hs_st = 0, hb_st = 0, hl_st = 0, hs_last = -1, vs_st = 0, vb_st = 0, wk_last = -1;
  bit wk_prev = 0, exp_odd = 0;

  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (en) begin
        tick++;
        if (h_pos == '0) lt++;
        if (hsync && !p_hs) begin
          hs_st = tick;
          observe(K_HSO, int'(h_pos));
          if (hs_last >= 0) observe(K_HPER, tick - hs_last);
          hs_last = tick;
        end
        if (!hsync && p_hs) observe(K_HSW, tick - hs_st);
        if (hblank && !p_hb) begin hb_st = tick; hb_on = 1; end
        if (!hblank && p_hb && hb_on) observe(K_HBW, tick - hb_st);
        if (halfline && !p_hl) begin hl_st = tick; observe(K_HALF, int'(h_pos)); end
        if (!halfline && p_hl) chk("R5 halfline width", tick - hl_st, 1);
        if (vblank && !p_vb) begin vb_st = lt; vb_on = 1; observe(K_VBL, int'(v_line)); end
        if (!vblank && p_vb && vb_on) observe(K_VBW, lt - vb_st);
        if (vsync && !p_vs) begin vs_st = lt; observe(K_VSO, lt - vb_st); end
        if (!vsync && p_vs) observe(K_VSW, lt - vs_st);
        p_hs = hsync; p_hb = hblank; p_hl = halfline; p_vs = vsync; p_vb = vblank;
      end
      if (field_wake) begin
        if (wk_prev) chk("R9 wake longer than one clock", 2, 1);
        chk("R9 wake position", int'(h_pos), 0);
        chk("R9 wake line", int'(v_line), 0);
        exp_odd = ~exp_odd;
        chk("R9 odd_field", int'(odd_field), int'(exp_odd));
        if (wk_last >= 0) observe(K_FLD, lt - wk_last);
        wk_last = lt;
        hs_last = -1;
      end
      wk_prev = field_wake;
    end
    if (en_mode == 1) en = ~en;
    else en = (en_mode == 2);
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; psel = 1'b0; en_mode = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 h_pos", int'(h_pos), 0);
    chk("R1 v_line", int'(v_line), 0);
    chk("R1 hblank", int'(hblank), 1);
    chk("R1 vblank", int'(vblank), 1);
    chk("R1 hsync", int'(hsync), 0);
    chk("R1 vsync", int'(vsync), 0);
    chk("R1 halfline", int'(halfline), 0);
    chk("R1 field_wake", int'(field_wake), 0);
    chk("R1 odd_field", int'(odd_field), 0);
    repeat (3) @(negedge clk);
    chk("R2 h_pos held without enable", int'(h_pos), 0);
    chk("R2 hblank held without enable", int'(hblank), 1);
    expect_profile(1'b0);
    mon_on = 1'b1;
    en_mode = 1;
    repeat (20000) @(negedge clk);
    en_mode = 2;
    repeat (2) @(posedge field_wake);
    // Mid-field request: current field must keep profile A edges.
    repeat (2 * 384 + 20) @(negedge clk);
    psel = 1'b1;
    push(K_HSO, 323, "R10", 1);
    push(K_HBW, 80, "R10", 1);
    @(posedge field_wake);
    repeat (800) @(negedge clk);
    expect_profile(1'b1);
    repeat (2) @(posedge field_wake);
    repeat (4) @(negedge clk);
    for (int k = 0; k < NK; k++) chk({kreq[k], " expected items left"}, q[k].size(), 0);
    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule